// File: doc/BRIEF.md
# Output Audio Stream Control and Status Register

This block is the 32-bit control and status word for one outbound audio stream of a DMA engine. Software reads and writes it through a plain register port with per-byte write enables. The word holds the stream reset and run controls, three interrupt enables and the routing fields (stream number, direction, priority, stripe control). It also holds three sticky event flags that the DMA hardware raises: a descriptor fetch failure, a FIFO underrun while buffers are still pending, and a buffer completion whose descriptor asked for an interrupt.

The block drives the stream run line, a level interrupt request and a suppress line. While the suppress line is high, the link transmitter must place no data for this stream. A descriptor fetch failure halts the stream by clearing the run bit in the same edge that latches the flag. The flags are write-one-to-clear. A flag latches even when its interrupt is masked.

The register port has no flow control. A write takes effect at the clock edge where `reg_wr` is high, so there is no back-pressure to observe. Read data is a combinational view of the stored state.

Top module: `astrm_ctl_reg`

## Requirements
- R1: After reset the read word is 0x00040000. Bits 31:30 and 25:24 always read 0, whatever is written to them.
- R2: Control bits sit in byte 0: bit 0 stream reset, bit 1 run, bit 2 completion interrupt enable, bit 3 underrun interrupt enable, bit 4 descriptor-error interrupt enable. Routing sits in byte 2: bits 23:20 stream number, bit 19 direction, bit 18 priority, bits 17:16 stripe control. A write changes only the lanes whose byte enable is 1.
- R3: Bit 29 reads the `fifo_level_ok` input as sampled at the previous clock edge. It is 0 after reset, and writes to it have no effect.
- R4: When `evt_desc_err` is high at an edge, bit 28 becomes 1 and run becomes 0 at that edge. This holds even if software writes run=1 in the same cycle. Run can be set again once bit 28 has been cleared.
- R5: When `evt_underrun` is high, bit 27 becomes 1. `tx_suppress` is high whenever `evt_underrun` is high or run is 0.
- R6: Bit 26 becomes 1 only at an edge where both `evt_buf_done` and `evt_buf_ioc` are high.
- R7: Bits 28:26 clear only when software writes 1 to their position with byte enable 3 set. Writing 0 leaves them unchanged.
- R8: A flag latches even when its interrupt enable is 0.
- R9: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R10: `irq` is high exactly when any flag is 1 together with its enable. Bit 26 pairs with bit 2, bit 27 with bit 3, and bit 28 with bit 4.
- R11: While stream reset (bit 0) is 1, run and bits 28:26 are forced to 0. This includes the write that sets bit 0, and events and run writes are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| evt_desc_err | input | 1 | Descriptor fetch failed |
| evt_underrun | input | 1 | FIFO underrun with buffers still pending |
| evt_buf_done | input | 1 | Last sample of a buffer processed |
| evt_buf_ioc | input | 1 | Interrupt-on-completion flag of that buffer's descriptor |
| fifo_level_ok | input | 1 | FIFO holds enough data to feed the link |
| stream_run | output | 1 | Stream enabled |
| stream_rst | output | 1 | Stream reset control |
| stream_num | output | 4 | Stream number |
| stream_dir | output | 1 | Direction control |
| traffic_pri | output | 1 | Traffic priority |
| stripe_ctl | output | 2 | Stripe control |
| tx_suppress | output | 1 | Send no data on the link for this stream |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes run=1 in the same cycle as a descriptor failure. A design that let software win that race would keep streaming after a fatal fetch error. It also lands a hardware set and a write-one-to-clear on one flag in the same cycle, where the wrong priority silently loses an underrun. Completion without the descriptor's interrupt flag must leave bit 26 low, and flags must latch while their enables are 0; either mistake would drop or invent interrupts. Stream reset is checked to clear and then hold the flags and run against new events and run writes, and partial byte-enable writes are checked to leave untouched lanes alone.

// File: rtl/astrm_pkg.sv
package astrm_pkg;
  localparam int REG_W     = 32;
  localparam int STS_N     = 3;
  localparam int STS_LSB   = 26;
  localparam int FRDY_BIT  = 29;
  localparam int SRST_BIT  = 0;
  localparam int RUN_BIT   = 1;
  localparam int IE_LSB    = 2;
  localparam int ROUTE_LSB = 16;
  localparam int SNUM_W    = 4;
  localparam int STRIPE_W  = 2;
  localparam logic [REG_W-1:0] RST_WORD = 32'h0004_0000;

  // flag index inside the status vector
  localparam int ST_BUF  = 0;
  localparam int ST_FIFO = 1;
  localparam int ST_DESC = 2;

  typedef struct packed {
    logic [SNUM_W-1:0]   num;
    logic                dir;
    logic                pri;
    logic [STRIPE_W-1:0] stripe;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);
endpackage

// File: rtl/astrm_ctl_bank.sv
module astrm_ctl_bank
  import astrm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic [7:0]         ctl_wdata,
  input  logic               wr_route,
  input  logic [ROUTE_W-1:0] route_wdata,
  input  logic               stop_req,
  output logic               srst_d,
  output logic               srst_q,
  output logic               run_q,
  output logic [STS_N-1:0]   ie_q,
  output route_t             route_q
);
  logic             run_d;
  logic [STS_N-1:0] ie_d;

  always_comb begin
    srst_d = wr_ctl ? ctl_wdata[SRST_BIT] : srst_q;
    run_d  = wr_ctl ? ctl_wdata[RUN_BIT]  : run_q;
    ie_d   = wr_ctl ? ctl_wdata[IE_LSB +: STS_N] : ie_q;
    if (srst_d || stop_req) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= RST_WORD[SRST_BIT];
      run_q   <= RST_WORD[RUN_BIT];
      ie_q    <= RST_WORD[IE_LSB +: STS_N];
      route_q <= route_t'(RST_WORD[ROUTE_LSB +: ROUTE_W]);
    end else begin
      srst_q <= srst_d;
      run_q  <= run_d;
      ie_q   <= ie_d;
      if (wr_route) route_q <= route_t'(route_wdata);
    end
  end

  // R4
  desc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !run_q);

  // R11
  srst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> !run_q);
endmodule

// File: rtl/astrm_sts_bank.sv
module astrm_sts_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         hold,
  output logic [N-1:0] sts_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts_q[i] <= 1'b0;
      else if (hold)   sts_q[i] <= 1'b0;
      else if (set[i]) sts_q[i] <= 1'b1;
      else if (clr[i]) sts_q[i] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && !hold) |=> sts_q[i]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !clr[i] && !hold) |=> sts_q[i]);

    // R11
    hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !sts_q[i]);
  end
endmodule

// File: rtl/astrm_ctl_reg.sv
module astrm_ctl_reg
  import astrm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [3:0]          reg_be,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                evt_desc_err,
  input  logic                evt_underrun,
  input  logic                evt_buf_done,
  input  logic                evt_buf_ioc,
  input  logic                fifo_level_ok,
  output logic                stream_run,
  output logic                stream_rst,
  output logic [SNUM_W-1:0]   stream_num,
  output logic                stream_dir,
  output logic                traffic_pri,
  output logic [STRIPE_W-1:0] stripe_ctl,
  output logic                tx_suppress,
  output logic                irq
);
  logic             srst_d, srst_q, run_q, frdy_q;
  logic [STS_N-1:0] ie_q, sts_set, sts_clr, sts_q;
  route_t           route_q;
  logic             unused_ok;

  assign unused_ok = ^{reg_be[1], reg_wdata[31:29], reg_wdata[25:24],
                       reg_wdata[15:8], reg_wdata[7:5]};

  assign sts_set[ST_BUF]  = evt_buf_done && evt_buf_ioc;
  assign sts_set[ST_FIFO] = evt_underrun;
  assign sts_set[ST_DESC] = evt_desc_err;
  assign sts_clr = (reg_wr && reg_be[3]) ? reg_wdata[STS_LSB +: STS_N] : '0;

  astrm_ctl_bank u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctl      (reg_wr && reg_be[0]),
    .ctl_wdata   (reg_wdata[7:0]),
    .wr_route    (reg_wr && reg_be[2]),
    .route_wdata (reg_wdata[ROUTE_LSB +: ROUTE_W]),
    .stop_req    (evt_desc_err),
    .srst_d      (srst_d),
    .srst_q      (srst_q),
    .run_q       (run_q),
    .ie_q        (ie_q),
    .route_q     (route_q)
  );

  astrm_sts_bank #(.N(STS_N)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sts_set),
    .clr   (sts_clr),
    .hold  (srst_d),
    .sts_q (sts_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frdy_q <= 1'b0;
    else        frdy_q <= fifo_level_ok;
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[SRST_BIT]                 = srst_q;
    reg_rdata[RUN_BIT]                  = run_q;
    reg_rdata[IE_LSB +: STS_N]          = ie_q;
    reg_rdata[ROUTE_LSB +: ROUTE_W]     = route_q;
    reg_rdata[STS_LSB +: STS_N]         = sts_q;
    reg_rdata[FRDY_BIT]                 = frdy_q;
  end

  assign stream_run  = run_q;
  assign stream_rst  = srst_q;
  assign stream_num  = route_q.num;
  assign stream_dir  = route_q.dir;
  assign traffic_pri = route_q.pri;
  assign stripe_ctl  = route_q.stripe;
  assign tx_suppress = evt_underrun || !run_q;
  assign irq         = |(sts_q & ie_q);

  // R3
  frdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> reg_rdata[FRDY_BIT] == $past(fifo_level_ok));

  // R6
  cmpl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q[ST_BUF] && !(evt_buf_done && evt_buf_ioc)) |=> !sts_q[ST_BUF]);
endmodule

// File: tb/sim_astrm_ctl_reg.sv
module sim_astrm_ctl_reg;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        evt_desc_err = 0, evt_underrun = 0, evt_buf_done = 0, evt_buf_ioc = 0;
  logic        fifo_level_ok = 0;
  logic        stream_run, stream_rst, stream_dir, traffic_pri, tx_suppress, irq;
  logic [3:0]  stream_num;
  logic [1:0]  stripe_ctl;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  astrm_ctl_reg u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset word", reg_rdata, 32'h0004_0000);
    chk("R1 run", {31'b0, stream_run}, 0);
    chk("R10 irq", {31'b0, irq}, 0);
    chk("R5 suppress idle", {31'b0, tx_suppress}, 1);
  endtask

  task automatic t_fields;
    wr(32'h00A3_0006, 4'b0101);
    chk("R2 word", reg_rdata, 32'h00A3_0006);
    chk("R2 num", {28'b0, stream_num}, 32'hA);
    chk("R2 stripe", {30'b0, stripe_ctl}, 3);
    chk("R5 running", {31'b0, tx_suppress}, 0);
    wr(32'hFFFF_FFFF, 4'b0010);
    chk("R2 lane masked", reg_rdata, 32'h00A3_0006);
  endtask

  task automatic t_frdy;
    @(negedge clk) fifo_level_ok = 1;
    @(negedge clk);
    chk("R3 ready high", {31'b0, reg_rdata[29]}, 1);
    wr(32'h2000_0000, 4'b1000);
    chk("R3 ro", {31'b0, reg_rdata[29]}, 1);
    fifo_level_ok = 0;
    @(negedge clk);
    chk("R3 ready low", {31'b0, reg_rdata[29]}, 0);
  endtask

  task automatic pulse_done(input logic ioc);
    @(negedge clk) begin evt_buf_done = 1; evt_buf_ioc = ioc; end
    @(negedge clk) begin evt_buf_done = 0; evt_buf_ioc = 0; end
  endtask

  task automatic t_cmpl;
    pulse_done(0);
    chk("R6 no ioc", {31'b0, reg_rdata[26]}, 0);
    pulse_done(1);
    chk("R6 ioc", {31'b0, reg_rdata[26]}, 1);
    chk("R10 cmpl irq", {31'b0, irq}, 1);
    wr(32'h0, 4'b1000);
    chk("R7 write0 keeps", {31'b0, reg_rdata[26]}, 1);
    wr(32'h0400_0000, 4'b1000);
    chk("R7 w1c", {31'b0, reg_rdata[26]}, 0);
    chk("R10 irq drop", {31'b0, irq}, 0);
  endtask

  task automatic t_underrun;
    @(negedge clk) evt_underrun = 1;
    #1 chk("R5 suppress on underrun", {31'b0, tx_suppress}, 1);
    @(negedge clk) evt_underrun = 0;
    chk("R8 masked latch", {31'b0, reg_rdata[27]}, 1);
    chk("R8 no irq", {31'b0, irq}, 0);
    wr(32'h0000_000E, 4'b0001);
    chk("R10 fifo irq", {31'b0, irq}, 1);
    @(negedge clk) begin
      evt_underrun = 1; reg_wr = 1; reg_wdata = 32'h0800_0000; reg_be = 4'b1000;
    end
    @(negedge clk) begin evt_underrun = 0; reg_wr = 0; reg_be = 0; end
    chk("R9 set wins", {31'b0, reg_rdata[27]}, 1);
    wr(32'h0800_0000, 4'b1000);
    chk("R7 clear fifo", {31'b0, reg_rdata[27]}, 0);
  endtask

  task automatic t_desc;
    @(negedge clk) begin
      evt_desc_err = 1; reg_wr = 1; reg_wdata = 32'h2; reg_be = 4'b0001;
    end
    @(negedge clk) begin evt_desc_err = 0; reg_wr = 0; reg_be = 0; end
    chk("R4 run stopped", {31'b0, stream_run}, 0);
    chk("R4 flag", {31'b0, reg_rdata[28]}, 1);
    chk("R4 suppress", {31'b0, tx_suppress}, 1);
    wr(32'h1000_0000, 4'b1000);
    wr(32'h0000_0012, 4'b0001);
    chk("R4 restart", {31'b0, stream_run}, 1);
    chk("R4 flag cleared", {31'b0, reg_rdata[28]}, 0);
  endtask

  task automatic t_srst;
    @(negedge clk) evt_underrun = 1;
    @(negedge clk) evt_underrun = 0;
    wr(32'h0000_0013, 4'b0001);
    chk("R11 run forced", {31'b0, stream_run}, 0);
    chk("R11 flags cleared", {29'b0, reg_rdata[28:26]}, 0);
    @(negedge clk) evt_desc_err = 1;
    @(negedge clk) evt_desc_err = 0;
    chk("R11 flag held", {31'b0, reg_rdata[28]}, 0);
    chk("R11 irq", {31'b0, irq}, 0);
    wr(32'h0000_0012, 4'b0001);
    chk("R11 released", {31'b0, stream_run}, 1);
    wr(32'hC300_0000, 4'b1000);
    chk("R1 reserved", {28'b0, reg_rdata[31:30], reg_rdata[25:24]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_frdy();
    t_cmpl();
    t_underrun();
    t_desc();
    t_srst();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule